// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block watches the write cycles of a byte-wide asynchronous flash bus after that bus has been brought into a clock domain, and works out which command sequence the host is issuing. Multi-byte commands start with two fixed address/data unlock writes. A third write then selects identifier read, a single-byte program, or erase setup. Erase setup needs a second unlock pair and a final chip-erase or sector-erase byte. There are also single-write commands for reset, erase suspend, erase resume and entering the parameter query table.

The decoder moves a mode register between read array, identifier read, query, program armed, program running, sector-erase collection window, erase running, erase suspended and failed. It issues one-cycle start, suspend and resume pulses to the program and erase engines, and those engines answer with done and fail pulses. Each cycle it also tells the read path which source to put on the data bus: array, identifier byte, query table or status. The identifier byte is produced here.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A bus write counts only while chip enable and write enable are both low and output enable is high. Its address is the one present on the first sampled cycle of that window, and its data is the one present on the last sampled cycle.
- R2: After reset the mode code is 0 (read array), rd_sel is 0 (array) and no pulse output is high.
- R3: The unlock pair is 0xAA at 0x555 followed by 0x55 at 0x2AA. Only the low UNLOCK_W (11) address bits are compared. A third write at 0x555 of 0x90 gives mode 1 (identifier), 0xA0 gives mode 3 (program armed), and 0x80 arms erase setup.
- R4: In mode 1, rd_sel is 1 and id_byte depends on read address bits [1:0]: 0 gives MFR_ID (0xC2), 1 gives DEV_ID (0x4F), 2 gives 0x01 when prot_map bit [addr[18:16]] is set and 0x00 otherwise, and 3 gives 0x00. Writes other than reset and query entry are ignored.
- R5: In mode 3 the next write pulses prog_start for one cycle, carrying that write's address and data, and sets mode 4 (program running). An eng_done pulse returns the mode to the base mode.
- R6: After erase setup, a second unlock pair followed by 0x10 at 0x555 pulses erase_start with erase_all=1 and sets mode 6 (erase running).
- R7: After erase setup and a second unlock pair, 0x30 at any address sets mode 5 and sets erase_mask bit [addr[18:16]]. Each further 0x30 write adds its sector and restarts a WIN_CYCLES window. When the window runs out with no write, erase_start pulses with erase_all=0 and the mode becomes 6.
- R8: In mode 5, a write that is neither 0x30 nor 0xB0 returns the mode to 0, clears erase_mask and starts no erase.
- R9: In modes 4 and 6 every write is ignored, including reset 0xF0. The one exception is 0xB0 during a sector erase.
- R10: 0xB0 during a running sector erase pulses susp_req and gives mode 7 (suspended). 0xB0 inside the collection window also gives mode 7, but no pulse is sent. In mode 7, 0x30 returns to mode 6 and pulses resume_req, or pulses erase_start if the erase had not yet begun.
- R11: An eng_fail pulse in mode 4 or 6 gives mode 8. Mode 8 reports rd_sel 3 and is left only by 0xF0, which gives mode 0.
- R12: 0x98 written with low address bits 0x55 in mode 0, 1 or 7 gives mode 2, with rd_sel 2. Mode 2 ignores every write except 0xF0, which restores the mode held before entry.
- R13: The base mode is 7 while an erase is suspended and 0 otherwise. A write that breaks an unlock or command sequence, including 0xF0 partway through, returns the block to the base mode with the sequence cleared.
- R14: In mode 7, rd_sel is 3 for reads inside a sector of erase_mask and 0 elsewhere. Programming is allowed and returns to mode 7 on completion. Erase setup (0x80) counts as a sequence break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Flash bus chip enable, active low |
| bus_we_n | input | 1 | Flash bus write enable, active low |
| bus_oe_n | input | 1 | Flash bus output enable, active low |
| bus_addr | input | ADDR_W | Flash bus byte address |
| bus_din | input | 8 | Flash bus write data |
| eng_done | input | 1 | Engine finished pulse |
| eng_fail | input | 1 | Engine failed pulse |
| prot_map | input | 2**SECT_BITS | Per-sector protect flags |
| mode_code | output | 4 | Current mode (encoding in R2 to R14) |
| rd_sel | output | 2 | Read source: 0 array, 1 identifier, 2 query, 3 status |
| id_byte | output | 8 | Identifier byte for the current read address |
| prog_start | output | 1 | One-cycle program start |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | 8 | Program data |
| erase_start | output | 1 | One-cycle erase start |
| erase_all | output | 1 | Whole-array erase when high |
| erase_mask | output | 2**SECT_BITS | Sectors selected for erase |
| susp_req | output | 1 | One-cycle erase suspend request |
| resume_req | output | 1 | One-cycle erase resume request |

## Verification
The hardest state to reach from the ports is a suspended erase whose start is still pending: 0xB0 has to land inside the sector collection window, before the window expires. The stimulus reaches it by shortening WIN_CYCLES on the bench and writing the suspend byte right after the sector write. It then waits well beyond the window to show that the halted window does not fire, and issues resume to see the delayed erase_start. A similar timing case restarts the window with a second sector write, then checks that no start appears after the first window would have run out.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

   typedef enum logic [3:0] {
      M_READ      = 4'd0,
      M_ID        = 4'd1,
      M_QUERY     = 4'd2,
      M_PROG_WAIT = 4'd3,
      M_PROG_BUSY = 4'd4,
      M_ERASE_WIN = 4'd5,
      M_ERASE_BSY = 4'd6,
      M_SUSP      = 4'd7,
      M_FAIL      = 4'd8
   } mode_t;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_U1   = 3'd1,
      PH_U2   = 3'd2,
      PH_E3   = 3'd3,
      PH_E4   = 3'd4,
      PH_E5   = 3'd5
   } phase_t;

   localparam logic [7:0] C_UNLK1 = 8'hAA;
   localparam logic [7:0] C_UNLK2 = 8'h55;
   localparam logic [7:0] C_IDENT = 8'h90;
   localparam logic [7:0] C_PROG  = 8'hA0;
   localparam logic [7:0] C_ERSET = 8'h80;
   localparam logic [7:0] C_CHIP  = 8'h10;
   localparam logic [7:0] C_SECT  = 8'h30;
   localparam logic [7:0] C_RST   = 8'hF0;
   localparam logic [7:0] C_SUSP  = 8'hB0;
   localparam logic [7:0] C_QUERY = 8'h98;

   localparam logic [1:0] RS_ARRAY  = 2'd0;
   localparam logic [1:0] RS_IDENT  = 2'd1;
   localparam logic [1:0] RS_QUERY  = 2'd2;
   localparam logic [1:0] RS_STATUS = 2'd3;

endpackage

// File: rtl/fcc_bus_capture.sv
module fcc_bus_capture #(
   parameter int ADDR_W      = 19,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data
);
   localparam int BW = ADDR_W + 8 + 3;

   logic [BW-1:0] raw;
   logic [BW-1:0] smp;
   assign raw = {ce_n, we_n, oe_n, addr, din};

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign smp = raw;
      end else begin : g_sync
         logic [BW-1:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '1;
            end else begin
               stg[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign smp = stg[SYNC_STAGES-1];
      end
   endgenerate

   logic              s_ce_n, s_we_n, s_oe_n;
   logic [ADDR_W-1:0] s_addr;
   logic [7:0]        s_din;
   assign {s_ce_n, s_we_n, s_oe_n, s_addr, s_din} = smp;

   logic act, act_q;
   logic [ADDR_W-1:0] addr_lat;
   logic [7:0]        dat_lat;

   assign act = !s_ce_n && !s_we_n && s_oe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         addr_lat <= '0;
         dat_lat  <= '0;
      end else begin
         act_q <= act;
         if (act && !act_q) addr_lat <= s_addr;
         if (act)           dat_lat  <= s_din;
      end
   end

   assign wr_stb  = act_q && !act;
   assign wr_addr = addr_lat;
   assign wr_data = dat_lat;

   // R1
   cap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

endmodule

// File: rtl/fcc_erase_win.sv
module fcc_erase_win #(
   parameter int SECT_BITS  = 3,
   parameter int WIN_CYCLES = 2500
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      arm,
   input  logic                      halt,
   input  logic                      clr,
   input  logic [SECT_BITS-1:0]      sect,
   output logic                      expire,
   output logic [(1<<SECT_BITS)-1:0] mask
);
   localparam int NSECT = 1 << SECT_BITS;
   localparam int CNT_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WIN_CYCLES - 1);

   logic [CNT_W-1:0] cnt;
   logic             run;
   logic [NSECT-1:0] sel;

   assign sel = NSECT'(1) << sect;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         run  <= 1'b0;
         mask <= '0;
      end else begin
         if (clr)      mask <= '0;
         else if (arm) mask <= mask | sel;
         if (arm) begin
            run <= 1'b1;
            cnt <= CNT_TOP;
         end else if (halt) begin
            run <= 1'b0;
         end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
         end
      end
   end

   assign expire = run && (cnt == '0) && !arm && !halt;

   // R7
   win_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (run && mask != '0));

   // R7
   win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !arm && !halt && cnt != '0) |=> (run && !expire || cnt == '0));

endmodule

// File: rtl/fcc_id_mux.sv
module fcc_id_mux #(
   parameter int         SECT_BITS = 3,
   parameter logic [7:0] MFR_ID    = 8'hC2,
   parameter logic [7:0] DEV_ID    = 8'h4F
) (
   input  logic [1:0]                offs,
   input  logic [SECT_BITS-1:0]      sect,
   input  logic [(1<<SECT_BITS)-1:0] prot_map,
   output logic [7:0]                id_byte
);
   localparam int NSECT = 1 << SECT_BITS;

   logic [NSECT-1:0] hit;
   genvar g;
   generate
      for (g = 0; g < NSECT; g++) begin : g_sect
         assign hit[g] = prot_map[g] && (sect == SECT_BITS'(g));
      end
   endgenerate

   always_comb begin
      case (offs)
         2'd0:    id_byte = MFR_ID;
         2'd1:    id_byte = DEV_ID;
         2'd2:    id_byte = {7'd0, |hit};
         default: id_byte = 8'h00;
      endcase
   end

   // R4
   id_prot_chk: assert final ((offs != 2'd2) || (id_byte[7:1] == 7'd0));

endmodule

// File: rtl/fcc_seq_fsm.sv
module fcc_seq_fsm
   import fcc_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int SECT_BITS = 3,
   parameter int UNLOCK_W  = 11
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_stb,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [7:0]                wr_data,
   input  logic                      eng_done,
   input  logic                      eng_fail,
   input  logic [SECT_BITS-1:0]      rd_sect,
   input  logic                      win_exp,
   input  logic [(1<<SECT_BITS)-1:0] win_mask,
   output logic [3:0]                mode_code,
   output logic [1:0]                rd_sel,
   output logic                      prog_start,
   output logic [ADDR_W-1:0]         prog_addr,
   output logic [7:0]                prog_data,
   output logic                      erase_start,
   output logic                      erase_all,
   output logic                      susp_req,
   output logic                      resume_req,
   output logic                      win_arm,
   output logic                      win_halt,
   output logic                      win_clr,
   output logic [SECT_BITS-1:0]      win_sect
);
   localparam logic [UNLOCK_W-1:0] A_555 = UNLOCK_W'('h555);
   localparam logic [UNLOCK_W-1:0] A_2AA = UNLOCK_W'('h2AA);
   localparam logic [UNLOCK_W-1:0] A_055 = UNLOCK_W'('h055);

   mode_t  mode, mode_n, ret_mode, ret_n;
   phase_t phase, phase_n;
   logic   susp_ctx, susp_n, pend, pend_n;
   logic   p_prog, p_erase, p_susp, p_res, all_n;
   logic [ADDR_W-1:0] paddr_n;
   logic [7:0]        pdata_n;
   logic   is555, is2aa, is055;
   mode_t  base;

   assign is555    = wr_addr[UNLOCK_W-1:0] == A_555;
   assign is2aa    = wr_addr[UNLOCK_W-1:0] == A_2AA;
   assign is055    = wr_addr[UNLOCK_W-1:0] == A_055;
   assign base     = susp_ctx ? M_SUSP : M_READ;
   assign win_sect = wr_addr[ADDR_W-1 -: SECT_BITS];

   always_comb begin
      mode_n   = mode;
      phase_n  = phase;
      ret_n    = ret_mode;
      susp_n   = susp_ctx;
      pend_n   = pend;
      p_prog   = 1'b0;
      p_erase  = 1'b0;
      p_susp   = 1'b0;
      p_res    = 1'b0;
      all_n    = erase_all;
      paddr_n  = prog_addr;
      pdata_n  = prog_data;
      win_arm  = 1'b0;
      win_halt = 1'b0;
      win_clr  = 1'b0;
      case (mode)
         M_PROG_BUSY: begin
            if (eng_fail) begin
               mode_n  = M_FAIL;
               susp_n  = 1'b0;
               pend_n  = 1'b0;
               win_clr = 1'b1;
            end else if (eng_done) begin
               mode_n = base;
            end
         end
         M_ERASE_BSY: begin
            if (eng_fail) begin
               mode_n  = M_FAIL;
               susp_n  = 1'b0;
               win_clr = 1'b1;
            end else if (eng_done) begin
               mode_n  = M_READ;
               susp_n  = 1'b0;
               win_clr = 1'b1;
            end else if (wr_stb && wr_data == C_SUSP && !erase_all) begin
               mode_n = M_SUSP;
               susp_n = 1'b1;
               p_susp = 1'b1;
            end
         end
         M_FAIL: begin
            if (wr_stb && wr_data == C_RST) begin
               mode_n  = M_READ;
               phase_n = PH_IDLE;
            end
         end
         M_QUERY: begin
            if (wr_stb && wr_data == C_RST) mode_n = ret_mode;
         end
         M_PROG_WAIT: begin
            if (wr_stb) begin
               p_prog  = 1'b1;
               paddr_n = wr_addr;
               pdata_n = wr_data;
               mode_n  = M_PROG_BUSY;
            end
         end
         M_ERASE_WIN: begin
            if (wr_stb) begin
               if (wr_data == C_SECT) begin
                  win_arm = 1'b1;
               end else if (wr_data == C_SUSP) begin
                  win_halt = 1'b1;
                  mode_n   = M_SUSP;
                  susp_n   = 1'b1;
                  pend_n   = 1'b1;
               end else begin
                  win_halt = 1'b1;
                  win_clr  = 1'b1;
                  mode_n   = M_READ;
               end
            end else if (win_exp) begin
               p_erase = 1'b1;
               all_n   = 1'b0;
               mode_n  = M_ERASE_BSY;
            end
         end
         default: begin
            if (wr_stb) begin
               case (phase)
                  PH_IDLE: begin
                     if (wr_data == C_RST) begin
                        mode_n = base;
                     end else if (wr_data == C_QUERY && is055) begin
                        ret_n  = mode;
                        mode_n = M_QUERY;
                     end else if (mode != M_ID && wr_data == C_UNLK1 && is555) begin
                        phase_n = PH_U1;
                     end else if (mode == M_SUSP && wr_data == C_SECT) begin
                        mode_n = M_ERASE_BSY;
                        susp_n = 1'b0;
                        pend_n = 1'b0;
                        all_n  = 1'b0;
                        if (pend) p_erase = 1'b1;
                        else      p_res   = 1'b1;
                     end
                  end
                  PH_U1: begin
                     if (wr_data == C_UNLK2 && is2aa) phase_n = PH_U2;
                     else begin phase_n = PH_IDLE; mode_n = base; end
                  end
                  PH_U2: begin
                     phase_n = PH_IDLE;
                     if (is555 && wr_data == C_IDENT)      mode_n = M_ID;
                     else if (is555 && wr_data == C_PROG)  mode_n = M_PROG_WAIT;
                     else if (is555 && wr_data == C_ERSET && mode == M_READ) phase_n = PH_E3;
                     else mode_n = base;
                  end
                  PH_E3: begin
                     if (wr_data == C_UNLK1 && is555) phase_n = PH_E4;
                     else begin phase_n = PH_IDLE; mode_n = base; end
                  end
                  PH_E4: begin
                     if (wr_data == C_UNLK2 && is2aa) phase_n = PH_E5;
                     else begin phase_n = PH_IDLE; mode_n = base; end
                  end
                  PH_E5: begin
                     phase_n = PH_IDLE;
                     if (wr_data == C_CHIP && is555) begin
                        p_erase = 1'b1;
                        all_n   = 1'b1;
                        mode_n  = M_ERASE_BSY;
                     end else if (wr_data == C_SECT) begin
                        win_arm = 1'b1;
                        all_n   = 1'b0;
                        mode_n  = M_ERASE_WIN;
                     end else begin
                        mode_n = base;
                     end
                  end
                  default: begin
                     phase_n = PH_IDLE;
                     mode_n  = base;
                  end
               endcase
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode        <= M_READ;
         phase       <= PH_IDLE;
         ret_mode    <= M_READ;
         susp_ctx    <= 1'b0;
         pend        <= 1'b0;
         prog_start  <= 1'b0;
         erase_start <= 1'b0;
         susp_req    <= 1'b0;
         resume_req  <= 1'b0;
         erase_all   <= 1'b0;
         prog_addr   <= '0;
         prog_data   <= '0;
      end else begin
         mode        <= mode_n;
         phase       <= phase_n;
         ret_mode    <= ret_n;
         susp_ctx    <= susp_n;
         pend        <= pend_n;
         prog_start  <= p_prog;
         erase_start <= p_erase;
         susp_req    <= p_susp;
         resume_req  <= p_res;
         erase_all   <= all_n;
         prog_addr   <= paddr_n;
         prog_data   <= pdata_n;
      end
   end

   assign mode_code = mode;

   always_comb begin
      case (mode)
         M_ID:        rd_sel = RS_IDENT;
         M_QUERY:     rd_sel = RS_QUERY;
         M_PROG_BUSY,
         M_ERASE_WIN,
         M_ERASE_BSY,
         M_FAIL:      rd_sel = RS_STATUS;
         M_SUSP:      rd_sel = win_mask[rd_sect] ? RS_STATUS : RS_ARRAY;
         default:     rd_sel = RS_ARRAY;
      endcase
   end

   // R5
   prog_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> (mode == M_PROG_BUSY));

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_PROG_BUSY && !eng_done && !eng_fail) |=> (mode == M_PROG_BUSY));

   // R10
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_start, erase_start, susp_req, resume_req}));

   // R11
   fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_FAIL && !(wr_stb && wr_data == C_RST)) |=> (mode == M_FAIL));

   // R12
   query_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_QUERY && !(wr_stb && wr_data == C_RST)) |=> (mode == M_QUERY));

   // R6
   erase_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |-> (mode == M_ERASE_BSY));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import fcc_pkg::*;
#(
   parameter int         ADDR_W      = 19,
   parameter int         SECT_BITS   = 3,
   parameter int         UNLOCK_W    = 11,
   parameter int         WIN_CYCLES  = 2500,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] MFR_ID      = 8'hC2,
   parameter logic [7:0] DEV_ID      = 8'h4F
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_ce_n,
   input  logic                      bus_we_n,
   input  logic                      bus_oe_n,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [7:0]                bus_din,
   input  logic                      eng_done,
   input  logic                      eng_fail,
   input  logic [(1<<SECT_BITS)-1:0] prot_map,
   output logic [3:0]                mode_code,
   output logic [1:0]                rd_sel,
   output logic [7:0]                id_byte,
   output logic                      prog_start,
   output logic [ADDR_W-1:0]         prog_addr,
   output logic [7:0]                prog_data,
   output logic                      erase_start,
   output logic                      erase_all,
   output logic [(1<<SECT_BITS)-1:0] erase_mask,
   output logic                      susp_req,
   output logic                      resume_req
);
   localparam int NSECT = 1 << SECT_BITS;

   generate
      if (UNLOCK_W < 11 || UNLOCK_W > ADDR_W) begin : g_bad_unlock
         $error("UNLOCK_W must lie between 11 and ADDR_W");
      end
      if (SECT_BITS < 1 || SECT_BITS > ADDR_W - 2) begin : g_bad_sect
         $error("SECT_BITS out of range for ADDR_W");
      end
      if (WIN_CYCLES < 2) begin : g_bad_win
         $error("WIN_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie between 0 and 4");
      end
   endgenerate

   logic              wr_stb;
   logic [ADDR_W-1:0] wr_addr;
   logic [7:0]        wr_data;
   logic              win_arm, win_halt, win_clr, win_exp;
   logic [SECT_BITS-1:0] win_sect;
   logic [SECT_BITS-1:0] rd_sect;

   assign rd_sect = bus_addr[ADDR_W-1 -: SECT_BITS];

   fcc_bus_capture #(
      .ADDR_W      (ADDR_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_n    (bus_ce_n),
      .we_n    (bus_we_n),
      .oe_n    (bus_oe_n),
      .addr    (bus_addr),
      .din     (bus_din),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   fcc_seq_fsm #(
      .ADDR_W    (ADDR_W),
      .SECT_BITS (SECT_BITS),
      .UNLOCK_W  (UNLOCK_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb      (wr_stb),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .eng_done    (eng_done),
      .eng_fail    (eng_fail),
      .rd_sect     (rd_sect),
      .win_exp     (win_exp),
      .win_mask    (erase_mask),
      .mode_code   (mode_code),
      .rd_sel      (rd_sel),
      .prog_start  (prog_start),
      .prog_addr   (prog_addr),
      .prog_data   (prog_data),
      .erase_start (erase_start),
      .erase_all   (erase_all),
      .susp_req    (susp_req),
      .resume_req  (resume_req),
      .win_arm     (win_arm),
      .win_halt    (win_halt),
      .win_clr     (win_clr),
      .win_sect    (win_sect)
   );

   fcc_erase_win #(
      .SECT_BITS  (SECT_BITS),
      .WIN_CYCLES (WIN_CYCLES)
   ) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (win_arm),
      .halt   (win_halt),
      .clr    (win_clr),
      .sect   (win_sect),
      .expire (win_exp),
      .mask   (erase_mask)
   );

   fcc_id_mux #(
      .SECT_BITS (SECT_BITS),
      .MFR_ID    (MFR_ID),
      .DEV_ID    (DEV_ID)
   ) u_id (
      .offs     (bus_addr[1:0]),
      .sect     (rd_sect),
      .prot_map (prot_map),
      .id_byte  (id_byte)
   );

   // R8
   abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 4'd5 && wr_stb && wr_data != 8'h30 && wr_data != 8'hB0)
         |=> (mode_code == 4'd0 && erase_mask == '0 && !erase_start));

   // R2
   mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 4'd0) |-> !(prog_start || susp_req || resume_req));

   logic [NSECT-1:0] unused_ok;
   assign unused_ok = '0;

endmodule

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
   localparam int AW  = 19;
   localparam int WIN = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0]    din = '0;
   logic          eng_done = 1'b0, eng_fail = 1'b0;
   logic [7:0]    prot_map = 8'h24;
   logic [3:0]    mode_code;
   logic [1:0]    rd_sel;
   logic [7:0]    id_byte;
   logic          prog_start, erase_start, erase_all, susp_req, resume_req;
   logic [AW-1:0] prog_addr;
   logic [7:0]    prog_data;
   logic [7:0]    erase_mask;

   int n_chk = 0, n_err = 0;
   int n_prog = 0, n_erase = 0, n_susp = 0, n_res = 0;
   logic [AW-1:0] last_pa;
   logic [7:0]    last_pd;
   logic          last_all;
   logic [7:0]    last_mask;
   bit            done = 1'b0;

   always #10 clk = ~clk;

   flash_cmd_ctrl #(.WIN_CYCLES(WIN)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
      .bus_addr(addr), .bus_din(din), .eng_done(eng_done), .eng_fail(eng_fail),
      .prot_map(prot_map), .mode_code(mode_code), .rd_sel(rd_sel), .id_byte(id_byte),
      .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
      .erase_start(erase_start), .erase_all(erase_all), .erase_mask(erase_mask),
      .susp_req(susp_req), .resume_req(resume_req));

   always @(posedge clk) begin
      if (prog_start) begin n_prog++; last_pa <= prog_addr; last_pd <= prog_data; end
      if (erase_start) begin n_erase++; last_all <= erase_all; last_mask <= erase_mask; end
      if (susp_req) n_susp++;
      if (resume_req) n_res++;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0;
      @(negedge clk); we_n = 1'b0;
      repeat (2) @(negedge clk);
      we_n = 1'b1;
      @(negedge clk); ce_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic wr_split(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                           input logic [7:0] d0, input logic [7:0] d1);
      @(negedge clk); addr = a0; din = d0; oe_n = 1'b1; ce_n = 1'b0;
      @(negedge clk); we_n = 1'b0;
      @(negedge clk); addr = a1; din = d1;
      repeat (2) @(negedge clk);
      we_n = 1'b1;
      @(negedge clk); ce_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic wr_oe_low(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; din = d; oe_n = 1'b0; ce_n = 1'b0;
      @(negedge clk); we_n = 1'b0;
      repeat (2) @(negedge clk);
      we_n = 1'b1;
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic unlock();
      wr(19'h00555, 8'hAA);
      wr(19'h002AA, 8'h55);
   endtask

   task automatic pulse_done();
      @(negedge clk); eng_done = 1'b1;
      @(negedge clk); eng_done = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse_fail();
      @(negedge clk); eng_fail = 1'b1;
      @(negedge clk); eng_fail = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic read_at(input logic [AW-1:0] a);
      @(negedge clk); addr = a; #1;
   endtask

   // vector: {addr[18:0], data[7:0], expected mode[3:0], requirement[3:0]}
   localparam int NV = 19;
   localparam logic [34:0] VEC [NV] = '{
      {19'h00555, 8'hAA, 4'd0, 4'd3},
      {19'h002AA, 8'h55, 4'd0, 4'd3},
      {19'h00555, 8'h90, 4'd1, 4'd3},
      {19'h00555, 8'h12, 4'd1, 4'd4},
      {19'h00055, 8'h98, 4'd2, 4'd12},
      {19'h00555, 8'hAA, 4'd2, 4'd12},
      {19'h00000, 8'hF0, 4'd1, 4'd12},
      {19'h00000, 8'hF0, 4'd0, 4'd13},
      {19'h7D555, 8'hAA, 4'd0, 4'd3},
      {19'h002AA, 8'h11, 4'd0, 4'd13},
      {19'h00555, 8'h90, 4'd0, 4'd13},
      {19'h00555, 8'hAA, 4'd0, 4'd6},
      {19'h012AA, 8'h55, 4'd0, 4'd3},
      {19'h00555, 8'h80, 4'd0, 4'd6},
      {19'h00555, 8'hAA, 4'd0, 4'd6},
      {19'h002AA, 8'h55, 4'd0, 4'd6},
      {19'h30000, 8'h30, 4'd5, 4'd7},
      {19'h50000, 8'h30, 4'd5, 4'd7},
      {19'h00000, 8'h77, 4'd0, 4'd8}
   };

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: reset state
      chk("R2 mode", mode_code, 0);
      chk("R2 rd_sel", rd_sel, 0);
      chk("R2 pulses", {prog_start, erase_start, susp_req, resume_req}, 0);

      // table walk (R3, R4, R6, R7, R8, R12, R13)
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][34:16], VEC[i][15:8]);
         n_chk++;
         if (mode_code != VEC[i][7:4]) begin
            n_err++;
            $display("FAIL vector %0d (R%0d): actual %0h expected %0h",
                     i, VEC[i][3:0], mode_code, VEC[i][7:4]);
         end
      end
      chk("R8 mask cleared", erase_mask, 0);
      chk("R8 no start", n_erase, 0);

      // R1: address from first cycle, data from last cycle, oe-low write ignored
      wr_split(19'h00555, 19'h00000, 8'h00, 8'hAA);
      wr_split(19'h002AA, 19'h00000, 8'h00, 8'h55);
      wr_oe_low(19'h00555, 8'h90);
      chk("R1 oe-low ignored", mode_code, 0);
      wr(19'h00555, 8'h90);
      chk("R1 split writes decoded", mode_code, 1);

      // R4: identifier reads
      read_at(19'h00000); chk("R4 rd_sel", rd_sel, 1); chk("R4 mfr", id_byte, 8'hC2);
      read_at(19'h00001); chk("R4 dev", id_byte, 8'h4F);
      read_at(19'h20002); chk("R4 prot sector2", id_byte, 8'h01);
      read_at(19'h30002); chk("R4 unprot sector3", id_byte, 8'h00);
      read_at(19'h50003); chk("R4 offset3", id_byte, 8'h00);
      wr(19'h00000, 8'hF0);
      chk("R4 exit", mode_code, 0);

      // R5 + R9: program, reset ignored while busy
      unlock(); wr(19'h00555, 8'hA0);
      chk("R5 armed", mode_code, 3);
      wr(19'h12345, 8'h3C);
      chk("R5 busy", mode_code, 4);
      chk("R5 count", n_prog, 1);
      chk("R5 addr", last_pa, 19'h12345);
      chk("R5 data", last_pd, 8'h3C);
      read_at(19'h00000); chk("R5 status sel", rd_sel, 3);
      wr(19'h00000, 8'hF0);
      chk("R9 reset ignored in program", mode_code, 4);
      pulse_done();
      chk("R5 done", mode_code, 0);

      // R6 + R9: chip erase, suspend ignored
      unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h00555, 8'h10);
      chk("R6 mode", mode_code, 6);
      chk("R6 count", n_erase, 1);
      chk("R6 all", last_all, 1);
      wr(19'h00000, 8'hB0);
      chk("R9 no suspend on chip erase", mode_code, 6);
      chk("R9 no susp_req", n_susp, 0);
      pulse_done();
      chk("R6 done", mode_code, 0);

      // R7: window restart by a second sector write
      unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h10000, 8'h30);
      repeat (15) @(negedge clk);
      wr(19'h60000, 8'h30);
      repeat (25) @(negedge clk);
      chk("R7 window restarted", n_erase, 1);
      chk("R7 still collecting", mode_code, 5);
      repeat (30) @(negedge clk);
      chk("R7 started", n_erase, 2);
      chk("R7 not all", last_all, 0);
      chk("R7 mask", last_mask, 8'h42);
      chk("R7 busy", mode_code, 6);

      // R10 + R14: suspend, reads, program in suspend, query, resume
      wr(19'h00000, 8'hB0);
      chk("R10 suspended", mode_code, 7);
      chk("R10 susp_req", n_susp, 1);
      read_at(19'h10004); chk("R14 erasing sector status", rd_sel, 3);
      read_at(19'h20004); chk("R14 other sector array", rd_sel, 0);
      unlock(); wr(19'h00555, 8'hA0); wr(19'h20010, 8'h5A);
      chk("R14 program in suspend", mode_code, 4);
      pulse_done();
      chk("R14 back to suspend", mode_code, 7);
      unlock(); wr(19'h00555, 8'h80);
      chk("R14 erase setup breaks", mode_code, 7);
      unlock(); wr(19'h00555, 8'h10);
      chk("R14 no erase from suspend", n_erase, 2);
      wr(19'h00055, 8'h98);
      chk("R12 query from suspend", mode_code, 2);
      read_at(19'h00010); chk("R12 rd_sel", rd_sel, 2);
      wr(19'h00000, 8'hF0);
      chk("R12 return to suspend", mode_code, 7);
      wr(19'h00000, 8'h30);
      chk("R10 resumed", mode_code, 6);
      chk("R10 resume_req", n_res, 1);
      pulse_done();
      chk("R10 done", mode_code, 0);
      chk("R10 mask cleared", erase_mask, 0);

      // R10: suspend inside window defers the start
      unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h70000, 8'h30);
      wr(19'h00000, 8'hB0);
      chk("R10 window suspend", mode_code, 7);
      repeat (WIN + 20) @(negedge clk);
      chk("R10 pending no start", n_erase, 2);
      chk("R10 no susp_req in window", n_susp, 1);
      wr(19'h00000, 8'h30);
      chk("R10 pending start", n_erase, 3);
      chk("R10 pending mask", last_mask, 8'h80);
      chk("R10 no resume_req", n_res, 1);
      pulse_done();

      // R11: fail state
      unlock(); wr(19'h00555, 8'hA0); wr(19'h00100, 8'h00);
      pulse_fail();
      chk("R11 fail", mode_code, 8);
      read_at(19'h00000); chk("R11 status", rd_sel, 3);
      wr(19'h00555, 8'hAA);
      chk("R11 stays", mode_code, 8);
      wr(19'h00000, 8'hF0);
      chk("R11 exit", mode_code, 0);

      // R13: reset partway through an erase sequence
      unlock(); wr(19'h00555, 8'h80); wr(19'h00555, 8'hAA); wr(19'h00000, 8'hF0);
      wr(19'h00555, 8'h10);
      chk("R13 partial reset no erase", n_erase, 3);
      chk("R13 read array", mode_code, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
         $finish;
      end
   end

endmodule